// File: doc/BRIEF.md
# Segment Translation and Limit Checker

This block turns a logical address, given as a segment number and a displacement, into a physical address. It looks the address up in a small table of segment descriptors. Each descriptor holds four things: a present flag, a base address, a length of its own, and separate permissions for read, write and execute. The segment number and the displacement arrive as separate fields of the request.

For every request the block returns one registered response. The response carries either the translated address or a single fault code. The fault says why the access was refused: the segment is absent, the displacement is outside the segment, or the kind of access is not permitted. Descriptors are loaded through a plain write port, one entry per cycle.

A typical user is a memory pipeline. It issues one request per cycle and acts on the fault code a cycle later.

Top module: `seg_xlate`

## Requirements
- R1: During and after reset, `rsp_valid`, `rsp_fault` and `rsp_paddr` are zero. Every descriptor is cleared to not-present, so every request after reset answers with the missing-segment fault.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: A request to a segment whose present flag is 0 answers with fault code 1 (missing segment), whatever its displacement and access type.
- R4: In a present segment, a displacement greater than or equal to the stored length answers with fault code 2 (out of range). A segment of length 0 therefore faults on every displacement.
- R5: The access code is 0 for read, 1 for write, 2 for execute, and 3 for read-modify-write. Code 3 needs both read and write permission. The permission field has read at bit 0, write at bit 1 and execute at bit 2. In a present segment with the displacement in range, an access without its permission answers with fault code 3 (protection).
- R6: Only one fault is reported, with missing segment ranked above out of range, and out of range ranked above protection.
- R7: With fault code 0, `rsp_paddr` equals base plus displacement, modulo 2^24. With any fault, `rsp_paddr` is 0.
- R8: A descriptor write affects requests from the next cycle on. A request in the same cycle as the write sees the old descriptor, and a write to one segment leaves all the others unchanged.
- R9: While `rsp_valid` is low, `rsp_fault` and `rsp_paddr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Descriptor write enable |
| cfg_sel | input | 3 | Descriptor to write |
| cfg_present | input | 1 | Present flag to store |
| cfg_base | input | 24 | Base address to store |
| cfg_len | input | 17 | Segment length to store (0 to 65536) |
| cfg_perm | input | 3 | Permissions to store: bit0 read, bit1 write, bit2 execute |
| req_valid | input | 1 | Request strobe |
| req_seg | input | 3 | Segment number of the request |
| req_disp | input | 16 | Displacement of the request |
| req_acc | input | 2 | Access type code |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_fault | output | 2 | 0 none, 1 missing, 2 out of range, 3 protection |
| rsp_paddr | output | 24 | Translated address, zero on fault |

## Verification
The hardest case to reach from the ports is a descriptor write and a request to the same segment in the same clock edge. The bench drives both in one cycle. It expects the old descriptor's answer in the next cycle and the new one on the following request. Fault priority also needs care, because every lower-ranked fault must be present at the same time as the higher one. The bench sweeps each segment's displacement across the edges of its length. It crosses every access code with all eight permission patterns, and it loads an absent segment that has zero length and no permissions.

// File: rtl/seg_xlate_pkg.sv
// Shared codes for the segment translator.
// Assumes: two-bit fault and access codes, three permission bits.
package seg_xlate_pkg;
    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_MISSING = 2'd1,
        FLT_RANGE   = 2'd2,
        FLT_PROT    = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RMW   = 2'd3
    } acc_e;

    localparam int PERM_W   = 3;
    localparam int PERM_RD  = 0;
    localparam int PERM_WR  = 1;
    localparam int PERM_EX  = 2;
endpackage

// File: rtl/seg_desc_table.sv
// Descriptor storage: one register set per segment, written one entry per cycle.
// Read is combinational, so a write becomes visible on the cycle after it.
// Assumes: reset clears every present flag.
module seg_desc_table #(
    parameter int NUM_SEG = 8,
    parameter int SEG_W   = 3,
    parameter int BASE_W  = 24,
    parameter int LEN_W   = 17,
    parameter int PERM_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_sel,
    input  logic              wr_present,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic [SEG_W-1:0]  rd_sel,
    output logic              rd_present,
    output logic [BASE_W-1:0] rd_base,
    output logic [LEN_W-1:0]  rd_len,
    output logic [PERM_W-1:0] rd_perm
);
    logic [NUM_SEG-1:0] ent_present;
    logic [BASE_W-1:0]  ent_base [NUM_SEG];
    logic [LEN_W-1:0]   ent_len  [NUM_SEG];
    logic [PERM_W-1:0]  ent_perm [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
        // Hold one descriptor; load it when this entry is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_present[g] <= 1'b0;
                ent_base[g]    <= '0;
                ent_len[g]     <= '0;
                ent_perm[g]    <= '0;
            end else if (wr_en && (wr_sel == SEG_W'(g))) begin
                ent_present[g] <= wr_present;
                ent_base[g]    <= wr_base;
                ent_len[g]     <= wr_len;
                ent_perm[g]    <= wr_perm;
            end
        end
    end

    // Select the descriptor addressed by the request.
    always_comb begin
        rd_present = ent_present[rd_sel];
        rd_base    = ent_base[rd_sel];
        rd_len     = ent_len[rd_sel];
        rd_perm    = ent_perm[rd_sel];
    end
endmodule

// File: rtl/seg_fault_eval.sv
// Combinational check of one request against its descriptor.
// Picks the single highest-ranked fault and forms base + displacement.
// Assumes: the length is one bit wider than the displacement.
module seg_fault_eval
    import seg_xlate_pkg::*;
#(
    parameter int DISP_W = 16,
    parameter int BASE_W = 24,
    parameter int LEN_W  = DISP_W + 1
) (
    input  logic              present,
    input  logic [BASE_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic [PERM_W-1:0] perm,
    input  logic [DISP_W-1:0] disp,
    input  logic [1:0]        acc,
    output logic [1:0]        fault,
    output logic [BASE_W-1:0] paddr
);
    logic in_range;
    logic allowed;

    // The displacement must be strictly below the segment length.
    always_comb in_range = ({1'b0, disp} < len);

    // Map the access code onto the permission bits it needs.
    always_comb begin
        unique case (acc_e'(acc))
            ACC_READ:  allowed = perm[PERM_RD];
            ACC_WRITE: allowed = perm[PERM_WR];
            ACC_EXEC:  allowed = perm[PERM_EX];
            default:   allowed = perm[PERM_RD] & perm[PERM_WR];
        endcase
    end

    // Pick the highest-ranked fault; give an address only when there is none.
    always_comb begin
        paddr = '0;
        if (!present)       fault = FLT_MISSING;
        else if (!in_range) fault = FLT_RANGE;
        else if (!allowed)  fault = FLT_PROT;
        else begin
            fault = FLT_NONE;
            paddr = base + BASE_W'(disp);
        end
    end
endmodule

// File: rtl/seg_xlate.sv
// Top of the segment translator: descriptor table, fault check and the
// one-cycle response register.
// Assumes: one request per cycle and no back-pressure on the response.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG = 8,
    parameter int DISP_W  = 16,
    parameter int BASE_W  = 24,
    localparam int SEG_W  = $clog2(NUM_SEG),
    localparam int LEN_W  = DISP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEG_W-1:0]  cfg_sel,
    input  logic              cfg_present,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [2:0]        cfg_perm,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [1:0]        req_acc,
    output logic              rsp_valid,
    output logic [1:0]        rsp_fault,
    output logic [BASE_W-1:0] rsp_paddr
);
    logic              d_present;
    logic [BASE_W-1:0] d_base;
    logic [LEN_W-1:0]  d_len;
    logic [PERM_W-1:0] d_perm;
    logic [1:0]        nxt_fault;
    logic [BASE_W-1:0] nxt_paddr;

    seg_desc_table #(
        .NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .BASE_W(BASE_W),
        .LEN_W(LEN_W), .PERM_W(PERM_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_present(cfg_present),
        .wr_base(cfg_base), .wr_len(cfg_len), .wr_perm(cfg_perm),
        .rd_sel(req_seg),
        .rd_present(d_present), .rd_base(d_base),
        .rd_len(d_len), .rd_perm(d_perm)
    );

    seg_fault_eval #(
        .DISP_W(DISP_W), .BASE_W(BASE_W), .LEN_W(LEN_W)
    ) u_eval (
        .present(d_present), .base(d_base), .len(d_len), .perm(d_perm),
        .disp(req_disp), .acc(req_acc),
        .fault(nxt_fault), .paddr(nxt_paddr)
    );

    // Register the response; the fields are zero when there is no request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= FLT_NONE;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= req_valid ? nxt_fault : FLT_NONE;
            rsp_paddr <= req_valid ? nxt_paddr : '0;
        end
    end
endmodule

// File: rtl/seg_xlate_chk.sv
// Property checker for seg_xlate, bound to every instance.
// Keeps a shadow copy of the present flags taken from the write port.
module seg_xlate_chk #(
    parameter int NUM_SEG = 8,
    parameter int SEG_W   = 3,
    parameter int BASE_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [SEG_W-1:0]  cfg_sel,
    input logic              cfg_present,
    input logic              req_valid,
    input logic [SEG_W-1:0]  req_seg,
    input logic              rsp_valid,
    input logic [1:0]        rsp_fault,
    input logic [BASE_W-1:0] rsp_paddr
);
    logic [NUM_SEG-1:0] shadow_present;

    // Track which segments have been written as present.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_present <= '0;
        else if (cfg_we) shadow_present[cfg_sel] <= cfg_present;
    end

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_rsp_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_absent_gives_missing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !shadow_present[req_seg]) |=> (rsp_fault == 2'd1));
    p_fault_zero_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_fault == 2'd0 && rsp_paddr == '0));
endmodule

bind seg_xlate seg_xlate_chk #(
    .NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .BASE_W(BASE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_present(cfg_present), .req_valid(req_valid), .req_seg(req_seg),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic        cfg_present = 1'b0;
    logic [23:0] cfg_base = '0;
    logic [16:0] cfg_len = '0;
    logic [2:0]  cfg_perm = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_seg = '0;
    logic [15:0] req_disp = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_fault;
    logic [23:0] rsp_paddr;

    int total = 0;
    int bad = 0;

    logic        m_present [8];
    logic [23:0] m_base    [8];
    logic [16:0] m_len     [8];
    logic [2:0]  m_perm    [8];

    always #2.5 clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_present(cfg_present), .cfg_base(cfg_base), .cfg_len(cfg_len),
        .cfg_perm(cfg_perm), .req_valid(req_valid), .req_seg(req_seg),
        .req_disp(req_disp), .req_acc(req_acc), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    function automatic logic [1:0] exp_fault(input int s, input logic [15:0] d, input logic [1:0] a);
        logic ok;
        case (a)
            2'd0: ok = m_perm[s][0];
            2'd1: ok = m_perm[s][1];
            2'd2: ok = m_perm[s][2];
            default: ok = m_perm[s][0] & m_perm[s][1];
        endcase
        if (!m_present[s]) return 2'd1;
        if ({1'b0, d} >= m_len[s]) return 2'd2;
        if (!ok) return 2'd3;
        return 2'd0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_desc(input int s, input logic p, input logic [23:0] b,
                              input logic [16:0] l, input logic [2:0] pm);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(s); cfg_present = p;
        cfg_base = b; cfg_len = l; cfg_perm = pm;
        @(negedge clk);
        cfg_we = 1'b0;
        m_present[s] = p; m_base[s] = b; m_len[s] = l; m_perm[s] = pm;
    endtask

    // One request; compares fault and address against the model.
    task automatic probe(input string req, input int s, input logic [15:0] d, input logic [1:0] a);
        logic [1:0]  ef;
        logic [23:0] ea;
        ef = exp_fault(s, d, a);
        ea = (ef == 2'd0) ? m_base[s] + 24'(d) : 24'd0;
        @(negedge clk);
        req_valid = 1'b1; req_seg = 3'(s); req_disp = d; req_acc = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " fault"}, 32'(rsp_fault), 32'(ef));
        check({req, " paddr"}, 32'(rsp_paddr), 32'(ea));
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_present[i] = 1'b0; m_base[i] = '0; m_len[i] = '0; m_perm[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check("R1 reset valid", 32'(rsp_valid), 32'd0);
        check("R1 reset fault", 32'(rsp_fault), 32'd0);
        check("R1 reset paddr", 32'(rsp_paddr), 32'd0);
        rst_n = 1'b1;
        // R1, R3: every segment missing after reset
        for (int s = 0; s < 8; s++) probe("R1 R3 post-reset", s, 16'h1234, 2'(s));
        // R9, R2: idle cycle has no response
        @(negedge clk);
        check("R2 R9 idle valid", 32'(rsp_valid), 32'd0);
        check("R9 idle fault", 32'(rsp_fault), 32'd0);

        // Load varied descriptors; segment 7 absent with no length or rights (R6)
        for (int s = 0; s < 7; s++)
            write_desc(s, 1'b1, 24'hFF_F000 - 24'(s * 24'h31_0101),
                       17'(s * 9001 + 1), 3'(s + 1));
        write_desc(3, 1'b1, 24'hFF_FFF0, 17'h10000, 3'b111); // R7 wrap, full length
        write_desc(6, 1'b1, 24'h00_4000, 17'd0, 3'b111);     // R4 zero length

        // R4 R5 R6 R7: displacement around the length edge, all access codes
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 6; k++) begin
                logic [16:0] l;
                logic [15:0] d;
                l = m_len[s];
                case (k)
                    0: d = 16'd0;
                    1: d = 16'd1;
                    2: d = 16'(l - 17'd1);
                    3: d = 16'(l);
                    4: d = 16'(l + 17'd1);
                    default: d = 16'hFFFF;
                endcase
                for (int a = 0; a < 4; a++) probe("R4 R5 R6 R7 sweep", s, d, 2'(a));
            end
        end

        // R5: every permission pattern against every access code
        for (int p = 0; p < 8; p++) begin
            write_desc(2, 1'b1, 24'h12_0000, 17'd256, 3'(p));
            for (int a = 0; a < 4; a++) probe("R5 perm cross", 2, 16'd77, 2'(a));
        end

        // R6: absent segment with every other fault also present
        write_desc(5, 1'b0, 24'h0, 17'd0, 3'b000);
        probe("R6 missing over range and prot", 5, 16'hFFFF, 2'd3);
        write_desc(5, 1'b1, 24'h0, 17'd0, 3'b000);
        probe("R6 range over prot", 5, 16'd0, 2'd1);

        // R8: write and request to the same segment in one cycle
        write_desc(4, 1'b0, 24'h0, 17'd0, 3'b000);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd4; cfg_present = 1'b1;
        cfg_base = 24'hABC000; cfg_len = 17'd100; cfg_perm = 3'b001;
        req_valid = 1'b1; req_seg = 3'd4; req_disp = 16'd5; req_acc = 2'd0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R8 same-cycle old view", 32'(rsp_fault), 32'd1);
        m_present[4] = 1'b1; m_base[4] = 24'hABC000; m_len[4] = 17'd100; m_perm[4] = 3'b001;
        probe("R8 new view", 4, 16'd5, 2'd0);
        // R8: neighbours untouched
        probe("R8 neighbour", 3, 16'h0020, 2'd2);
        probe("R8 neighbour", 0, 16'd0, 2'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule